// File: doc/BRIEF.md
# Write-Before-Read Register File

This block is a general-purpose register file for a pipelined core. It has one write port and two independent read ports. It behaves as if each write lands in the first half of a clock cycle and both reads happen in the second half. An instruction that reads a register in the same cycle that an older instruction writes it back therefore sees the new value. One physical write port is then shared in time with the reads, with no extra forwarding stage.

Everything runs on the rising edge of a single clock; there is no half-cycle clock. The storage array updates on the rising edge. Each read port compares its address with the write address while the write is enabled and, on a match, selects the incoming write data instead of the stored word.

Register 0 is hard-wired to zero. Only one write per cycle can be accepted. A companion input carries any competing write-back request, which the file must never see together with a real write.

Top module: `regfile_wbr`

## Requirements
- R1: A synchronous active-low reset clears every register. After reset is released, every address reads zero on both ports until it is written.
- R2: When `wr_en` is high at a rising edge and `wr_addr` is not 0, `wr_data` is stored at `wr_addr` and is returned by later reads of that address.
- R3: In a cycle where `wr_en` is high and `rd0_addr` equals a nonzero `wr_addr`, `rd0_data` shows `wr_data` in that same cycle.
- R4: The same-cycle forwarding of R3 also applies to read port 1, on its own and at the same time as port 0.
- R5: A read of address 0 on either port always returns zero.
- R6: A write to address 0 is ignored. It is not stored, and it is not forwarded to a same-cycle read of address 0.
- R7: While `wr_en` is low, `wr_addr` and `wr_data` change no register and are not forwarded.
- R8: A read of an address other than the one being written in the same cycle returns that register's stored (old) value.
- R9: `wr_dup_req` flags a second write-back in the same cycle and must never be high while `wr_en` is high. It never writes or changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the array updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W (5) | Write address |
| wr_data | input | DATA_W (32) | Write data |
| wr_dup_req | input | 1 | Competing second write request (must not coincide with wr_en) |
| rd0_addr | input | ADDR_W (5) | Read port 0 address |
| rd1_addr | input | ADDR_W (5) | Read port 1 address |
| rd0_data | output | DATA_W (32) | Read port 0 data |
| rd1_data | output | DATA_W (32) | Read port 1 data |

## Verification
Read data is combinational and is due in the same cycle as the read address, including the forwarded value during a write. Stored values are due from the cycle after the rising edge that commits the write. The bench applies every stimulus at the falling edge and samples the read ports 5 ns later, before the next rising edge. It updates its expected-content model only after that rising edge, so same-cycle forwarding and committed contents are checked in separate, fixed cycles.

// File: rtl/rfw_pkg.sv
// Package: shared defaults for the write-before-read register file.
// Assumes: consumers override these through module parameters where needed.
package rfw_pkg;
    localparam int RFW_DEF_REGS   = 32;
    localparam int RFW_DEF_WIDTH  = 32;
    localparam int RFW_RD_PORTS   = 2;
endpackage

// File: rtl/rfw_wdec.sv
// Module: write-address decoder producing one strobe per storable register.
// Assumes: entry 0 is hard-wired and never receives a strobe.
module rfw_wdec #(
    parameter int NUM_REGS = rfw_pkg::RFW_DEF_REGS,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    output logic [NUM_REGS-1:0] wr_stb
);
    // Register 0 never gets a strobe.
    assign wr_stb[0] = 1'b0;

    generate
        for (genvar g = 1; g < NUM_REGS; g++) begin : g_dec
            // Strobe entry g when the enabled write targets it.
            assign wr_stb[g] = wr_en && (wr_addr == ADDR_W'(g));
        end
    endgenerate
endmodule

// File: rtl/rfw_store.sv
// Module: storage array, one register per nonzero entry, rising-edge update.
// Assumes: at most one strobe is high per cycle; entry 0 is a constant zero.
module rfw_store #(
    parameter int NUM_REGS = rfw_pkg::RFW_DEF_REGS,
    parameter int DATA_W   = rfw_pkg::RFW_DEF_WIDTH
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              wr_stb,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  cells
);
    // Entry 0 is hard-wired to zero.
    assign cells[0] = '0;

    generate
        for (genvar g = 1; g < NUM_REGS; g++) begin : g_cell
            logic [DATA_W-1:0] q;
            // Hold, clear on reset, or load when this entry is strobed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_stb[g]) begin
                    q <= wr_data;
                end
            end
            assign cells[g] = q;
        end
    endgenerate
endmodule

// File: rtl/rfw_rport.sv
// Module: one read port with same-cycle forwarding of the pending write.
// Assumes: wr_fwd is already qualified so that it is never high for address 0.
module rfw_rport #(
    parameter int NUM_REGS = rfw_pkg::RFW_DEF_REGS,
    parameter int DATA_W   = rfw_pkg::RFW_DEF_WIDTH,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] cells,
    input  logic                            wr_fwd,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [DATA_W-1:0]               rd_data
);
    logic hit;

    // Address match against the write that lands earlier in this cycle.
    assign hit = wr_fwd && (rd_addr == wr_addr);

    // Forward the new value on a match, otherwise return the stored word.
    always_comb begin
        if (rd_addr == '0) begin
            rd_data = '0;
        end else if (hit) begin
            rd_data = wr_data;
        end else begin
            rd_data = cells[rd_addr];
        end
    end
endmodule

// File: rtl/regfile_wbr.sv
// Module: register file with one write port and RFW_RD_PORTS read ports.
// A write appears to land before the reads of the same cycle: reads of the
// address being written return the new data through a forwarding path.
// Assumes: a single write per cycle; register 0 reads as zero.
module regfile_wbr #(
    parameter  int NUM_REGS = rfw_pkg::RFW_DEF_REGS,
    parameter  int DATA_W   = rfw_pkg::RFW_DEF_WIDTH,
    localparam int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dup_req,
    input  logic [ADDR_W-1:0] rd0_addr,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd0_data,
    output logic [DATA_W-1:0] rd1_data
);
    localparam int NRD = rfw_pkg::RFW_RD_PORTS;

    logic [NUM_REGS-1:0]             wr_stb;
    logic [NUM_REGS-1:0][DATA_W-1:0] cells;
    logic                            wr_fwd;
    logic [NRD-1:0][ADDR_W-1:0]      rd_addr_v;
    logic [NRD-1:0][DATA_W-1:0]      rd_data_v;

    // The second write request only feeds the bound checker.
    logic unused_dup;
    assign unused_dup = wr_dup_req;

    // Forwarding is only allowed for a write to a real register.
    assign wr_fwd = wr_en && (wr_addr != '0);

    // Gather and scatter the read port buses.
    assign rd_addr_v[0] = rd0_addr;
    assign rd_addr_v[1] = rd1_addr;
    assign rd0_data     = rd_data_v[0];
    assign rd1_data     = rd_data_v[1];

    rfw_wdec #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_stb   (wr_stb)
    );

    rfw_store #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .cells    (cells)
    );

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            rfw_rport #(
                .NUM_REGS (NUM_REGS),
                .DATA_W   (DATA_W),
                .ADDR_W   (ADDR_W)
            ) u_port (
                .rd_addr  (rd_addr_v[p]),
                .cells    (cells),
                .wr_fwd   (wr_fwd),
                .wr_addr  (wr_addr),
                .wr_data  (wr_data),
                .rd_data  (rd_data_v[p])
            );
        end
    endgenerate
endmodule

// File: rtl/rfw_chk.sv
// Module: protocol and behaviour checker for regfile_wbr, attached by bind.
// Assumes: it sees only the top-level ports.
module rfw_chk #(
    parameter int NUM_REGS = rfw_pkg::RFW_DEF_REGS,
    parameter int DATA_W   = rfw_pkg::RFW_DEF_WIDTH,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_dup_req,
    input logic [ADDR_W-1:0] rd0_addr,
    input logic [ADDR_W-1:0] rd1_addr,
    input logic [DATA_W-1:0] rd0_data,
    input logic [DATA_W-1:0] rd1_data
);
    // R9
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_dup_req));

    // R5
    zero_reg_rd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_addr == '0) |-> (rd0_data == '0));

    // R5
    zero_reg_rd1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_addr == '0) |-> (rd1_data == '0));

    // R3
    fwd_rd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd0_addr == wr_addr) |-> (rd0_data == wr_data));

    // R4
    fwd_rd1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd1_addr == wr_addr) |-> (rd1_data == wr_data));

    // R2
    commit_rd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) != '0
         && rd0_addr == $past(wr_addr) && !(wr_en && wr_addr == rd0_addr))
        |-> (rd0_data == $past(wr_data)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        ($past(!rst_n) && rst_n && !wr_en) |-> (rd0_data == '0 && rd1_data == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && !wr_en && $stable(rd0_addr))
        |-> $stable(rd0_data));
endmodule

bind regfile_wbr rfw_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_dup_req (wr_dup_req),
    .rd0_addr   (rd0_addr),
    .rd1_addr   (rd1_addr),
    .rd0_data   (rd0_data),
    .rd1_data   (rd1_data)
);

// File: tb/sim_regfile_wbr.sv
// Bench: sweeps every address of the default configuration, computing
// expected read data from an independent content model.
module sim_regfile_wbr;
    localparam int NR = 32;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_dup_req = 1'b0;
    logic [AW-1:0] rd0_addr = '0;
    logic [AW-1:0] rd1_addr = '0;
    logic [DW-1:0] rd0_data;
    logic [DW-1:0] rd1_data;

    logic [DW-1:0] model [NR];
    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    regfile_wbr u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_dup_req (wr_dup_req),
        .rd0_addr   (rd0_addr),
        .rd1_addr   (rd1_addr),
        .rd0_data   (rd0_data),
        .rd1_data   (rd1_data)
    );

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i, input int k);
        return (DW'(i) * 32'h0101_0101) ^ ((k == 0) ? 32'h5A00_00C3 : 32'hC300_A55A);
    endfunction

    // Expected read: zero register, then same-cycle forward, then stored word.
    function automatic logic [DW-1:0] exp_rd(input logic we, input logic [AW-1:0] wa,
                                             input logic [DW-1:0] wd, input logic [AW-1:0] ra);
        if (ra == '0) return '0;
        if (we && wa == ra) return wd;
        return model[ra];
    endfunction

    // One cycle: drive at falling edge, sample 5 ns later, commit at rising edge.
    task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic dup, input logic [AW-1:0] ra0, input logic [AW-1:0] ra1,
                        input string r0, input string r1);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; wr_dup_req = dup;
        rd0_addr = ra0; rd1_addr = ra1;
        #5;
        chk(r0, rd0_data, exp_rd(we, wa, wd, ra0));
        chk(r1, rd1_data, exp_rd(we, wa, wd, ra1));
        @(posedge clk);
        if (we && wa != '0) model[wa] = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; wr_addr = AW'(3); wr_data = 32'hDEAD_BEEF;
        wr_dup_req = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < NR; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no finish expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: every address zero after reset.
        for (int a = 0; a < NR; a++)
            step(1'b0, '0, '0, 1'b0, AW'(a), AW'(NR - 1 - a), "R1 rd0", "R1 rd1");

        // R3 forward on port 0, R8 port 1 reads a not-yet-written neighbour.
        for (int a = 1; a < NR; a++)
            step(1'b1, AW'(a), pat(a, 0), 1'b0, AW'(a), AW'((a + 1) % NR), "R3", "R8");

        // R2 committed contents on both ports.
        for (int a = 0; a < NR; a++)
            step(1'b0, '0, '0, 1'b0, AW'(a), AW'(a), "R2 rd0", "R2 rd1");

        // R4 overwrite with forwarding on both ports at once.
        for (int a = 1; a < NR; a++)
            step(1'b1, AW'(a), pat(a, 1), 1'b0, AW'(a), AW'(a), "R4 rd0", "R4 rd1");

        // R8 port 0 reads an old neighbour while port 1 sees the forward.
        for (int a = 1; a < NR; a++)
            step(1'b1, AW'(a), pat(a, 0), 1'b0, AW'(NR - a), AW'(a), "R8", "R4");

        // R6 write to register 0: not forwarded, not stored; R5 zero reads.
        step(1'b1, '0, 32'hFFFF_FFFF, 1'b0, '0, '0, "R6 fwd", "R5");
        step(1'b0, '0, '0, 1'b0, '0, AW'(1), "R6 store", "R2");

        // R7 disabled write with live address/data changes nothing.
        for (int a = 1; a < NR; a++)
            step(1'b0, AW'(a), 32'h1234_5678, 1'b0, AW'(a), AW'(a), "R7 rd0", "R7 rd1");
        for (int a = 1; a < NR; a++)
            step(1'b0, '0, '0, 1'b0, AW'(a), AW'(NR - a), "R7 hold", "R7 hold");

        // R9 second write request alone has no effect on any register.
        for (int a = 1; a < NR; a++)
            step(1'b0, AW'(a), ~pat(a, 0), 1'b1, AW'(a), AW'(a), "R9 rd0", "R9 rd1");
        for (int a = 0; a < NR; a++)
            step(1'b0, '0, '0, 1'b0, AW'(a), AW'(a), "R9 after", "R9 after");

        // R1 reset in mid-run clears written contents.
        do_reset();
        for (int a = 0; a < NR; a++)
            step(1'b0, '0, '0, 1'b0, AW'(a), AW'(a), "R1 rerun", "R1 rerun");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule